// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave Behind a Pin Register

This block models a small serial EEPROM that host software drives by writing one byte register. Each byte carries a chip select, a serial clock, a data-in bit and a data-out bit. The block has no serial clock of its own. It compares each newly written byte with the byte it stored before, and reacts to the rising and falling edges it finds on chip select and on the serial clock.

A transaction begins when chip select rises. A start bit follows, then a 2-bit opcode, then an 8-bit address field whose low 7 bits pick one of 128 16-bit words. The block can read or write one word, erase one word, write one value to every word, erase every word, and turn write protection on or off. Read data leaves on the data-out bit, most significant bit first, and the host polls for it by reading the pin register. The storage is a register array inside the block. Writes finish at once, so there is no busy indication.

Top module: `ser_eeprom_port`

## Requirements
- R1: After reset the pin register reads 0x01, writes are disabled, and every word holds 0xFFFF. Serial clock edges are ignored until chip select (bit 7) has risen once.
- R2: A write to the pin register stores bits 7..1 as written. Bit 0 (data out) reads as 1 unless the block is driving it or holding it under R7. The value the host writes to bit 0 is discarded.
- R3: A rise of chip select returns the controller to idle and abandons any unfinished command. In idle, a rising serial clock (bit 6) that samples data in (bit 1) as 1 is a start bit, and a 0 is ignored. The next 10 rising edges shift in, MSB first, the opcode[1:0] and then an 8-bit address field.
- R4: Opcode 00 with address field bits [7:6] = 11 enables writes, and with [7:6] = 00 disables them. Either command takes effect on the 10th command edge.
- R5: Opcode 01 shifts in 16 data bits, MSB first, on the following rising edges. On the 16th edge it stores them at the addressed word, but only if writes are enabled.
- R6: Opcode 10 drives data out to 0 on its 10th command edge. Each of the next 16 rising edges then drives one bit of the addressed word, MSB first. After the 16th bit the controller is idle.
- R7: While chip select stays high, a falling serial clock edge that does not drive data out keeps its previous value.
- R8: Opcode 11 sets the addressed word to 0xFFFF on the 10th command edge, but only if writes are enabled.
- R9: Opcode 00 with field bits [7:6] = 01 shifts in 16 data bits and writes them to all 128 words, but only if writes are enabled.
- R10: Opcode 00 with field bits [7:6] = 10 sets all 128 words to 0xFFFF on the 10th command edge, but only if writes are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_wr | input | 1 | Write strobe for the pin register, one cycle per host write |
| pin_wdata | input | 8 | Byte written: bit 7 chip select, bit 6 serial clock, bit 1 data in |
| pin_rdata | output | 8 | Stored pin byte with the current data-out level in bit 0 |

## Verification
The bound checker watches rules that must hold on every cycle. The pin register changes only on a host write and keeps the upper seven bits that were written. Data out reads as 1 when nothing drives or holds it, and stays put across a falling clock with chip select high. The block drives data out only on a write that raises the serial clock. Array write strobes appear only with writes enabled, never both at once, and only on a rising clock edge. Some behaviour shows only in the bench's command sequences. These are the exact serial bit stream of a read, and the effect of protection on writes and erases, seen through later reads. They also cover the parked state after reset, and how a chip select rise abandons a half-sent command.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Bit positions inside the host pin byte (software depends on them)
  localparam int PIN_SEL = 7;
  localparam int PIN_SCK = 6;
  localparam int PIN_DIN = 1;
  localparam int PIN_DOUT = 0;

  typedef enum logic [2:0] {
    ST_PARK  = 3'd0,  // after reset, waiting for first select rise
    ST_IDLE  = 3'd1,  // waiting for start bit
    ST_CMD   = 3'd2,  // collecting opcode and address field
    ST_WRITE = 3'd3,  // collecting data for one word
    ST_WRALL = 3'd4,  // collecting data for every word
    ST_SHOUT = 3'd5   // shifting a word out on data out
  } eep_state_e;

endpackage

// File: rtl/eep_pin_reg.sv
module eep_pin_reg
  import eep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       do_drv,
  input  logic       do_val,
  output logic [7:0] pin_q,
  output logic       sel_rise,
  output logic       sck_rise,
  output logic       din
);

  logic [7:0] pin_r;
  logic [7:0] pin_n;
  logic       sck_fall;
  logic       dout_n;

  // Edges: stored byte against the byte being written now
  assign sel_rise = ~pin_r[PIN_SEL] & wr_data[PIN_SEL];
  assign sck_rise = ~pin_r[PIN_SCK] & wr_data[PIN_SCK];
  assign sck_fall = pin_r[PIN_SCK] & ~wr_data[PIN_SCK];
  assign din      = wr_data[PIN_DIN];

  always_comb begin
    if (do_drv) begin
      dout_n = do_val;
    end else if (wr_data[PIN_SEL] && sck_fall) begin
      dout_n = pin_r[PIN_DOUT];
    end else begin
      dout_n = 1'b1;  // line floats high
    end
    pin_n = {wr_data[7:1], dout_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_r <= 8'h01;
    end else if (wr_en) begin
      pin_r <= pin_n;
    end
  end

  assign pin_q = pin_r;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int WORDS  = 128,
  parameter int WIDTH  = 16,
  parameter int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic             hit;
    logic [WIDTH-1:0] word_q;

    assign hit = wr_all | (wr_one & (waddr == ADDR_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (hit) begin
        word_q <= wdata;
      end
    end

    assign words[g] = word_q;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              din,
  input  logic [WIDTH-1:0]  rdata,
  output logic              do_drv,
  output logic              do_val,
  output logic              wr_one,
  output logic              wr_all,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  wdata,
  output logic              we_q
);

  localparam int AF_W     = ADDR_W + 1;       // address field incl. sub-op bit
  localparam int CMD_BITS = AF_W + 2;         // opcode plus address field
  localparam int CNT_W    = $clog2(WIDTH + 1);

  eep_state_e        st_q, st_n, st_a;
  logic [WIDTH-1:0]  sr_q, sr_n, sr_sh;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_inc;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              we_n;
  logic              shift_en;
  logic [1:0]        op;
  logic [1:0]        sub;

  assign st_a     = sel_rise ? ST_IDLE : st_q;
  assign shift_en = (st_a == ST_CMD) || (st_a == ST_WRITE) || (st_a == ST_WRALL);
  assign sr_sh    = shift_en ? {sr_q[WIDTH-2:0], din} : sr_q;
  assign cnt_inc  = shift_en ? cnt_q + 1'b1 : cnt_q;
  assign op       = sr_sh[AF_W+1:AF_W];
  assign sub      = sr_sh[AF_W-1:AF_W-2];
  assign raddr    = sr_sh[ADDR_W-1:0];

  always_comb begin
    st_n   = st_q;
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    we_n   = we_q;
    wr_one = 1'b0;
    wr_all = 1'b0;
    waddr  = addr_q;
    wdata  = sr_sh;
    do_drv = 1'b0;
    do_val = 1'b0;
    if (wr_en) begin
      st_n = st_a;
      if (sck_rise) begin
        sr_n  = sr_sh;
        cnt_n = cnt_inc;
        case (st_a)
          ST_IDLE: begin
            if (din) begin
              st_n  = ST_CMD;
              sr_n  = '0;
              cnt_n = '0;
            end
          end
          ST_CMD: begin
            if (cnt_inc == CNT_W'(CMD_BITS)) begin
              cnt_n  = '0;
              addr_n = sr_sh[ADDR_W-1:0];
              case (op)
                2'b00: begin
                  case (sub)
                    2'b00: begin we_n = 1'b0; st_n = ST_IDLE; end
                    2'b11: begin we_n = 1'b1; st_n = ST_IDLE; end
                    2'b01: st_n = ST_WRALL;
                    default: begin
                      wr_all = we_q;
                      wdata  = '1;
                      st_n   = ST_IDLE;
                    end
                  endcase
                end
                2'b01: st_n = ST_WRITE;
                2'b10: begin
                  st_n   = ST_SHOUT;
                  sr_n   = rdata;
                  cnt_n  = CNT_W'(WIDTH);
                  do_drv = 1'b1;
                  do_val = 1'b0;  // leading dummy zero
                end
                default: begin
                  wr_one = we_q;
                  waddr  = sr_sh[ADDR_W-1:0];
                  wdata  = '1;
                  st_n   = ST_IDLE;
                end
              endcase
            end
          end
          ST_WRITE: begin
            if (cnt_inc == CNT_W'(WIDTH)) begin
              wr_one = we_q;
              cnt_n  = '0;
              st_n   = ST_IDLE;
            end
          end
          ST_WRALL: begin
            if (cnt_inc == CNT_W'(WIDTH)) begin
              wr_all = we_q;
              cnt_n  = '0;
              st_n   = ST_IDLE;
            end
          end
          ST_SHOUT: begin
            do_drv = 1'b1;
            do_val = sr_q[WIDTH-1];
            sr_n   = {sr_q[WIDTH-2:0], 1'b0};
            cnt_n  = cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              st_n = ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PARK;
      sr_q   <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      we_q   <= 1'b0;
    end else if (wr_en) begin
      st_q   <= st_n;
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      we_q   <= we_n;
    end
  end

endmodule

// File: rtl/ser_eeprom_port.sv
module ser_eeprom_port #(
  parameter int WORDS = 128,
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_wr,
  input  logic [7:0] pin_wdata,
  output logic [7:0] pin_rdata
);

  localparam int ADDR_W = $clog2(WORDS);

  logic              rst_m, rst_q;
  logic              sel_rise, sck_rise, din;
  logic              do_drv, do_val;
  logic              mem_wr_one, mem_wr_all;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [WIDTH-1:0]  mem_wdata, mem_rdata;
  logic              we_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  eep_pin_reg u_pin (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (pin_wr),
    .wr_data  (pin_wdata),
    .do_drv   (do_drv),
    .do_val   (do_val),
    .pin_q    (pin_rdata),
    .sel_rise (sel_rise),
    .sck_rise (sck_rise),
    .din      (din)
  );

  eep_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_en    (pin_wr),
    .sel_rise (sel_rise),
    .sck_rise (sck_rise),
    .din      (din),
    .rdata    (mem_rdata),
    .do_drv   (do_drv),
    .do_val   (do_val),
    .wr_one   (mem_wr_one),
    .wr_all   (mem_wr_all),
    .waddr    (mem_waddr),
    .raddr    (mem_raddr),
    .wdata    (mem_wdata),
    .we_q     (we_flag)
  );

  eep_array #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_one (mem_wr_one),
    .wr_all (mem_wr_all),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .raddr  (mem_raddr),
    .rdata  (mem_rdata)
  );

endmodule

// File: rtl/eep_chk.sv
module eep_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_wr,
  input logic [7:0] pin_wdata,
  input logic [7:0] pin_rdata,
  input logic       do_drv,
  input logic       wr_one,
  input logic       wr_all,
  input logic       we_q
);

  assert_upper_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_wr |=> pin_rdata[7:1] == $past(pin_wdata[7:1]));

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_wr |=> $stable(pin_rdata));

  assert_float_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_wr && !do_drv && !(pin_wdata[7] && pin_rdata[6] && !pin_wdata[6]))
      |=> pin_rdata[0]);

  assert_fall_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_wr && !do_drv && pin_wdata[7] && pin_rdata[6] && !pin_wdata[6])
      |=> pin_rdata[0] == $past(pin_rdata[0]));

  assert_drive_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_drv |-> (pin_wr && pin_wdata[6] && !pin_rdata[6]));

  assert_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one || wr_all) |-> we_q);

  assert_strobe_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_one || wr_all) |-> (pin_wr && pin_wdata[6] && !pin_rdata[6]));

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_one, wr_all}));

endmodule

bind ser_eeprom_port eep_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .pin_wr    (pin_wr),
  .pin_wdata (pin_wdata),
  .pin_rdata (pin_rdata),
  .do_drv    (do_drv),
  .wr_one    (mem_wr_one),
  .wr_all    (mem_wr_all),
  .we_q      (we_flag)
);

// File: tb/sim_ser_eeprom_port.sv
`timescale 1ns/1ps
module sim_ser_eeprom_port;

  logic       clk;
  logic       rst_n;
  logic       pin_wr;
  logic [7:0] pin_wdata;
  logic [7:0] pin_rdata;

  int   total = 0;
  int   fails = 0;
  bit   done  = 0;

  logic [15:0] mdl [128];
  bit          mwe;

  logic  exp_q [$];
  string tag_q [$];
  event  smp_ev;

  ser_eeprom_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_wr    (pin_wr),
    .pin_wdata (pin_wdata),
    .pin_rdata (pin_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected data-out bit for each sampled rising edge
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() == 0) begin
        chk("R6 scoreboard underflow", 16'd1, 16'd0);
      end else begin
        chk(tag_q.pop_front(), {15'd0, pin_rdata[0]}, {15'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic push(input logic v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
    ->smp_ev;
  endtask

  task automatic pin(input logic cs, input logic ck, input logic d);
    @(negedge clk);
    pin_wr    = 1'b1;
    pin_wdata = {cs, ck, 4'b0101, d, 1'b0};
    @(negedge clk);
    pin_wr    = 1'b0;
  endtask

  task automatic bitpair(input logic d);
    pin(1'b1, 1'b0, d);
    pin(1'b1, 1'b1, d);
  endtask

  task automatic start_cmd(input logic [1:0] op, input logic [7:0] af, input int lead);
    pin(1'b0, 1'b0, 1'b0);
    pin(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < lead; i++) bitpair(1'b0);
    bitpair(1'b1);
    for (int i = 1; i >= 0; i--) bitpair(op[i]);
    for (int i = 7; i >= 0; i--) bitpair(af[i]);
  endtask

  task automatic rd_word(input logic [6:0] a, input string t);
    logic prev;
    start_cmd(2'b10, {1'b0, a}, 0);
    push(1'b0, {t, " lead zero R6"});
    prev = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      pin(1'b1, 1'b0, 1'b0);
      chk("R7 hold on falling clock", {15'd0, pin_rdata[0]}, {15'd0, prev});
      pin(1'b1, 1'b1, 1'b0);
      push(mdl[a][i], t);
      prev = mdl[a][i];
    end
    pin(1'b0, 1'b0, 1'b0);
    chk("R2 data out floats after read", {15'd0, pin_rdata[0]}, 16'd1);
  endtask

  task automatic wr_word(input logic [6:0] a, input logic [15:0] v);
    start_cmd(2'b01, {1'b0, a}, 0);
    for (int i = 15; i >= 0; i--) bitpair(v[i]);
    if (mwe) mdl[a] = v;
    pin(1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_we(input bit en);
    start_cmd(2'b00, en ? 8'hC0 : 8'h00, 0);
    mwe = en;
    pin(1'b0, 1'b0, 1'b0);
  endtask

  task automatic erase(input logic [6:0] a);
    start_cmd(2'b11, {1'b0, a}, 0);
    if (mwe) mdl[a] = 16'hFFFF;
    pin(1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr_all(input logic [15:0] v);
    start_cmd(2'b00, 8'h40, 0);
    for (int i = 15; i >= 0; i--) bitpair(v[i]);
    if (mwe) for (int k = 0; k < 128; k++) mdl[k] = v;
    pin(1'b0, 1'b0, 1'b0);
  endtask

  task automatic erase_all();
    start_cmd(2'b00, 8'h80, 0);
    if (mwe) for (int k = 0; k < 128; k++) mdl[k] = 16'hFFFF;
    pin(1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [10:0] park_bits;
    for (int k = 0; k < 128; k++) mdl[k] = 16'hFFFF;
    mwe       = 0;
    pin_wr    = 1'b0;
    pin_wdata = 8'h00;
    rst_n     = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset pin byte", {8'd0, pin_rdata}, 16'h0001);

    // R1: read command clocked without any select rise must be ignored
    park_bits = {1'b1, 2'b10, 8'h05};
    for (int i = 10; i >= 0; i--) begin
      pin(1'b0, 1'b0, park_bits[i]);
      pin(1'b0, 1'b1, park_bits[i]);
    end
    chk("R1 parked, no data out drive", {15'd0, pin_rdata[0]}, 16'd1);
    pin(1'b0, 1'b0, 1'b0);

    // R2: readback of written byte, bit 0 written 0 reads 1
    pin(1'b1, 1'b0, 1'b0);
    chk("R2 readback byte", {8'd0, pin_rdata}, 16'h0095);
    pin(1'b1, 1'b0, 1'b1);
    chk("R2 readback with data in", {8'd0, pin_rdata}, 16'h0097);
    pin(1'b0, 1'b0, 1'b0);

    rd_word(7'd5, "R1 erased at reset");

    // R5: protected write has no effect
    wr_word(7'd5, 16'hA5C3);
    rd_word(7'd5, "R5 protected write");

    set_we(1);
    wr_word(7'd5, 16'hA5C3);
    wr_word(7'd127, 16'h0001);
    rd_word(7'd5, "R5 write word");
    rd_word(7'd127, "R6 read last word");

    // R3: leading zeros ignored in idle
    start_cmd(2'b10, 8'h05, 3);
    push(1'b0, "R3 idle zeros ignored");
    for (int i = 15; i >= 0; i--) begin
      pin(1'b1, 1'b0, 1'b0);
      pin(1'b1, 1'b1, 1'b0);
      push(mdl[5][i], "R3 idle zeros ignored");
    end
    pin(1'b0, 1'b0, 1'b0);

    // R3: select rise abandons a partial write
    pin(1'b0, 1'b0, 1'b0);
    pin(1'b1, 1'b0, 1'b0);
    bitpair(1'b1);
    bitpair(1'b0);
    bitpair(1'b1);
    bitpair(1'b0);
    rd_word(7'd127, "R3 abort on select rise");

    erase(7'd5);
    rd_word(7'd5, "R8 erase word");
    rd_word(7'd127, "R8 neighbour kept");

    wr_all(16'h1234);
    rd_word(7'd0, "R9 write all low");
    rd_word(7'd64, "R9 write all mid");

    erase_all();
    rd_word(7'd127, "R10 erase all");

    wr_word(7'd9, 16'h5A5A);
    set_we(0);
    wr_word(7'd9, 16'h0F0F);
    rd_word(7'd9, "R4 disable blocks write");
    erase(7'd9);
    rd_word(7'd9, "R8 protected erase");
    erase_all();
    rd_word(7'd9, "R10 protected erase all");
    wr_all(16'h0000);
    rd_word(7'd9, "R9 protected write all");

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", 16'(exp_q.size()), 16'd0);
    summary();
    $finish;
  end

endmodule